// File: doc/BRIEF.md
# Phase-Shift Controlled Switching Pattern Reader

This block produces the read address into a fixed, precomputed switching-pattern table for a power converter. It makes one full pass through the table for every line cycle, and it never computes or alters the pattern. The reactive power is regulated only by making the read run slightly faster or slower than the line, so the gating pattern slides in phase against the line voltage.

The read position is a 32-bit phase word. It is built from two parts. A nominal accumulator advances by a fixed increment every clock, and that increment is set so that one wrap takes exactly one line period. A signed phase offset is added to it. Every clock the offset moves by the scaled reactive-power error, and the direction of that move depends on the operating mode. The offset is held within a limit set at run time, so the loop can never slip a whole cycle.

A line-sync pulse first arms the reader. After that, each pulse captures the present offset into a monitor register, and the accumulator is not disturbed. Two instances are used in a system. One holds the current-source inverter gating near ±90 degrees. The other holds the voltage-source filter pattern near 0 degrees. That pattern has 20 chop angles and is read at 60 times line frequency, which is 3.6 kHz.

The control is a two-state machine:
- WAIT_SYNC: the reader is armed and idle. The phase is held at zero and the error is ignored.
- TRACK: the reader is running. Transition ARM goes from WAIT_SYNC to TRACK on the first line-sync pulse. TRACK loops on itself (transition RUN) until reset.

Top module: `phase_pattern_reader`

## Requirements
- R1: After reset, phase_word, tbl_addr and offset_mon are all 0. The block sits in WAIT_SYNC until line_sync is sampled high. While it waits, phase_word stays 0 whatever err_in and lead_mode hold.
- R2: From the first clock edge after the one that sampled the arming line_sync, phase_word advances by NOM_INC (default 0x0100_0000) on every edge while the offset is unchanged. It wraps modulo 2^32, so with the default increment one pass takes 256 clocks.
- R3: tbl_addr equals the ADDR_W most significant bits of phase_word (bits 31 down to 24 by default).
- R4: In TRACK with lead_mode=1, each edge adds err_in arithmetically shifted right by GAIN_SHIFT (default 4, which rounds toward minus infinity) to the offset. A positive error therefore speeds up the read. For example, err_in=160 adds 10 per clock and err_in=-17 adds -2.
- R5: In TRACK with lead_mode=0, each edge subtracts the same shifted error from the offset. A positive error therefore slows down the read.
- R6: The offset saturates at +off_limit and -off_limit. If off_limit is lowered below the present magnitude of the offset, the next edge pulls the offset to the new bound. phase_word always equals the nominal accumulator plus the offset, modulo 2^32.
- R7: An edge that samples line_sync high loads offset_mon with the offset held just before that edge. offset_mon holds its value between pulses. A pulse in TRACK does not reset or disturb phase_word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_sync | input | 1 | One-clock pulse per line cycle |
| err_in | input | ERR_W (16) | Signed reactive-power error |
| lead_mode | input | 1 | 1 = leading operation, 0 = lagging operation |
| off_limit | input | ACC_W-1 (31) | Magnitude bound on the phase offset |
| phase_word | output | ACC_W (32) | Read phase: nominal accumulator plus offset |
| tbl_addr | output | ADDR_W (8) | Pattern table address, top bits of phase_word |
| offset_mon | output | ACC_W (32) | Signed offset captured at the last line_sync |

## Verification
The bench goes after several corner cases. First, error ignored before arming: a design that starts tracking at reset would show a nonzero phase before the first sync. Second, the exact wrap after 256 clocks at zero error: an off-by-one in the accumulator start would leave the address one step early or late. Third, the floor rounding of a negative error: a design that rounds toward zero would add -1 instead of -2 per clock. Fourth, the sign flip between modes. Fifth, both ends of the clamp, including a limit lowered under a live offset: a design that only stops further growth would keep the stale larger offset. Sixth, the monitor timing: capturing the offset after the update, or resetting the accumulator on sync, shows up as a wrong offset_mon or a jump in phase_word.

// File: rtl/pat_rd_pkg.sv
package pat_rd_pkg;
    typedef enum logic [0:0] {
        RD_WAIT_SYNC = 1'b0,
        RD_TRACK     = 1'b1
    } rd_state_e;
endpackage

// File: rtl/pat_rd_trim.sv
// Signed per-clock offset step: error scaled by a right shift, sign set by mode.
module pat_rd_trim #(
    parameter int ERR_W      = 16,
    parameter int GAIN_SHIFT = 4,
    localparam int TRIM_W    = ERR_W + 1
) (
    input  logic signed [ERR_W-1:0]  err_in,
    input  logic                     lead_mode,
    output logic signed [TRIM_W-1:0] trim
);
    logic signed [ERR_W-1:0]  scaled;
    logic signed [TRIM_W-1:0] scaled_x;

    always_comb begin
        scaled   = err_in >>> GAIN_SHIFT;
        scaled_x = {scaled[ERR_W-1], scaled};
        trim     = lead_mode ? scaled_x : -scaled_x;
    end
endmodule

// File: rtl/pat_rd_offset.sv
// Phase offset register with symmetric saturation.
module pat_rd_offset #(
    parameter int OFF_W  = 32,
    parameter int TRIM_W = 17,
    localparam int SUM_W = OFF_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic signed [TRIM_W-1:0] trim,
    input  logic [OFF_W-2:0]         limit,
    output logic signed [OFF_W-1:0]  offset_q
);
    logic signed [SUM_W-1:0] sum;
    logic signed [SUM_W-1:0] lim_pos;
    logic signed [SUM_W-1:0] lim_neg;
    logic signed [SUM_W-1:0] clamped;

    always_comb begin
        sum     = {offset_q[OFF_W-1], offset_q}
                + {{(SUM_W-TRIM_W){trim[TRIM_W-1]}}, trim};
        lim_pos = {2'b00, limit};
        lim_neg = -lim_pos;
        if (sum > lim_pos)
            clamped = lim_pos;
        else if (sum < lim_neg)
            clamped = lim_neg;
        else
            clamped = sum;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            offset_q <= '0;
        else if (en)
            offset_q <= clamped[OFF_W-1:0];
    end
endmodule

// File: rtl/pat_rd_accum.sv
// Free-running nominal phase accumulator, one wrap per line period.
module pat_rd_accum #(
    parameter int ACC_W = 32,
    parameter logic [ACC_W-1:0] STEP = 32'h0100_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    output logic [ACC_W-1:0] acc_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            acc_q <= '0;
        else if (en)
            acc_q <= acc_q + STEP;
    end
endmodule

// File: rtl/phase_pattern_reader.sv
module phase_pattern_reader
    import pat_rd_pkg::*;
#(
    parameter int          ACC_W      = 32,
    parameter int          ERR_W      = 16,
    parameter int          GAIN_SHIFT = 4,
    parameter int          ADDR_W     = 8,
    parameter int unsigned NOM_INC    = 32'h0100_0000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    line_sync,
    input  logic signed [ERR_W-1:0] err_in,
    input  logic                    lead_mode,
    input  logic [ACC_W-2:0]        off_limit,
    output logic [ACC_W-1:0]        phase_word,
    output logic [ADDR_W-1:0]       tbl_addr,
    output logic signed [ACC_W-1:0] offset_mon
);
    localparam int               TRIM_W = ERR_W + 1;
    localparam logic [ACC_W-1:0] NOM_V  = ACC_W'(NOM_INC);

    rd_state_e state_q, state_d;
    logic      run_en;

    logic signed [TRIM_W-1:0] trim;
    logic signed [ACC_W-1:0]  offset_q;
    logic [ACC_W-1:0]         nom_acc;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= RD_WAIT_SYNC;
        else
            state_q <= state_d;
    end

    // Next state: ARM on first sync, RUN thereafter
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_WAIT_SYNC: if (line_sync) state_d = RD_TRACK;
            RD_TRACK:     state_d = RD_TRACK;
            default:      state_d = RD_WAIT_SYNC;
        endcase
    end

    // State outputs
    always_comb begin
        run_en = 1'b0;
        unique case (state_q)
            RD_WAIT_SYNC: run_en = 1'b0;
            RD_TRACK:     run_en = 1'b1;
            default:      run_en = 1'b0;
        endcase
    end

    pat_rd_trim #(
        .ERR_W      (ERR_W),
        .GAIN_SHIFT (GAIN_SHIFT)
    ) u_trim (
        .err_in    (err_in),
        .lead_mode (lead_mode),
        .trim      (trim)
    );

    pat_rd_offset #(
        .OFF_W  (ACC_W),
        .TRIM_W (TRIM_W)
    ) u_offset (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (run_en),
        .trim     (trim),
        .limit    (off_limit),
        .offset_q (offset_q)
    );

    pat_rd_accum #(
        .ACC_W (ACC_W),
        .STEP  (NOM_V)
    ) u_accum (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (run_en),
        .acc_q (nom_acc)
    );

    // Offset monitor, captured on every line sync
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            offset_mon <= '0;
        else if (line_sync)
            offset_mon <= offset_q;
    end

    always_comb begin
        phase_word = nom_acc + offset_q;
        tbl_addr   = phase_word[ACC_W-1 -: ADDR_W];
    end
endmodule

// File: rtl/phase_pattern_reader_chk.sv
module phase_pattern_reader_chk #(
    parameter int          ACC_W   = 32,
    parameter int          ERR_W   = 16,
    parameter int unsigned NOM_INC = 32'h0100_0000
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    line_sync,
    input logic signed [ERR_W-1:0] err_in,
    input logic                    lead_mode,
    input logic [ACC_W-2:0]        off_limit,
    input logic [ACC_W-1:0]        phase_word,
    input logic signed [ACC_W-1:0] offset_mon,
    input logic                    running,
    input logic signed [ACC_W-1:0] offset
);
    localparam logic [ACC_W-1:0] NOM_V = ACC_W'(NOM_INC);

    logic [ACC_W-1:0] off_mag;
    always_comb off_mag = offset[ACC_W-1] ? -offset : offset;

    // R1: idle reader holds zero phase
    p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> phase_word == '0);

    // R2: nominal step when error is zero and no clamp pulls the offset
    p_nominal_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(running) && $past(err_in) == '0 && {1'b0, $past(off_limit)} >= $past(off_mag))
        |-> phase_word == $past(phase_word) + NOM_V);

    // R4: leading mode with positive error never retards the offset
    p_lead_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(running) && $past(lead_mode) && $past(err_in) > 0
         && {1'b0, $past(off_limit)} >= $past(off_mag))
        |-> $signed(offset) >= $signed($past(offset)));

    // R5: lagging mode with positive error never advances the offset
    p_lag_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(running) && !$past(lead_mode) && $past(err_in) > 0
         && {1'b0, $past(off_limit)} >= $past(off_mag))
        |-> $signed(offset) <= $signed($past(offset)));

    // R6: offset magnitude within the limit in force at the last edge
    p_offset_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        off_mag <= {1'b0, $past(off_limit)});

    // R7: monitor captures the pre-edge offset on sync and holds otherwise
    p_mon_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        line_sync |=> offset_mon == $past(offset));

    p_mon_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !line_sync |=> $stable(offset_mon));
endmodule

bind phase_pattern_reader phase_pattern_reader_chk #(
    .ACC_W   (ACC_W),
    .ERR_W   (ERR_W),
    .NOM_INC (NOM_INC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_sync  (line_sync),
    .err_in     (err_in),
    .lead_mode  (lead_mode),
    .off_limit  (off_limit),
    .phase_word (phase_word),
    .offset_mon (offset_mon),
    .running    (run_en),
    .offset     (offset_q)
);

// File: tb/phase_pattern_reader_bench.sv
`timescale 1ns/1ps
module phase_pattern_reader_bench;
    localparam int          ACC_W  = 32;
    localparam int          ERR_W  = 16;
    localparam int          ADDR_W = 8;
    localparam int unsigned NOM    = 32'h0100_0000;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    line_sync = 1'b0;
    logic signed [ERR_W-1:0] err_in = '0;
    logic                    lead_mode = 1'b1;
    logic [ACC_W-2:0]        off_limit = 31'd1000;
    logic [ACC_W-1:0]        phase_word;
    logic [ADDR_W-1:0]       tbl_addr;
    logic signed [ACC_W-1:0] offset_mon;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // reference model state, built from the requirements
    bit          m_run;
    logic [31:0] m_nom;
    longint      m_off;
    longint      m_mon;

    always #2 clk = ~clk;

    phase_pattern_reader u_phase_pattern_reader (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_sync  (line_sync),
        .err_in     (err_in),
        .lead_mode  (lead_mode),
        .off_limit  (off_limit),
        .phase_word (phase_word),
        .tbl_addr   (tbl_addr),
        .offset_mon (offset_mon)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one clock: advance the model with the inputs in force, sample 1 ns after the edge
    task automatic tick();
        longint sh;
        longint d;
        @(posedge clk);
        sh = longint'(err_in) >>> 4;
        d  = lead_mode ? sh : -sh;
        if (line_sync) m_mon = m_off;
        if (m_run) begin
            m_nom = m_nom + NOM;
            m_off = m_off + d;
            if (m_off > longint'(off_limit))  m_off = longint'(off_limit);
            if (m_off < -longint'(off_limit)) m_off = -longint'(off_limit);
        end else if (line_sync) begin
            m_run = 1'b1;
        end
        #1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    function automatic longint exp_phase();
        logic [31:0] p;
        p = m_nom + 32'(m_off);
        return longint'(p);
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; line_sync = 1'b0; err_in = '0; lead_mode = 1'b1; off_limit = 31'd1000;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        m_run = 1'b0; m_nom = '0; m_off = 0; m_mon = 0;
    endtask

    task automatic arm();
        line_sync = 1'b1;
        tick();
        line_sync = 1'b0;
    endtask

    task automatic t_reset_idle();
        do_reset();
        chk("R1 phase after reset", longint'(phase_word), 0);
        chk("R1 addr after reset", longint'(tbl_addr), 0);
        chk("R1 mon after reset", longint'(offset_mon), 0);
        err_in = 16'sd2000; lead_mode = 1'b1;
        ticks(5);
        chk("R1 error ignored before sync", longint'(phase_word), 0);
        lead_mode = 1'b0;
        ticks(3);
        chk("R1 lagging error ignored before sync", longint'(phase_word), 0);
    endtask

    task automatic t_nominal();
        do_reset();
        arm();
        chk("R2 phase at arming edge", longint'(phase_word), 0);
        ticks(10);
        chk("R2 ten nominal steps", longint'(phase_word), 64'h0A00_0000);
        chk("R3 addr after ten steps", longint'(tbl_addr), 10);
        ticks(246);
        chk("R2 full pass wraps", longint'(phase_word), 0);
        chk("R3 addr wraps", longint'(tbl_addr), 0);
        ticks(1);
        chk("R3 addr first step of second pass", longint'(tbl_addr), 1);
    endtask

    task automatic t_lead();
        do_reset();
        arm();
        err_in = 16'sd160; lead_mode = 1'b1;
        ticks(5);
        chk("R4 leading positive error", longint'(phase_word), 64'h0500_0000 + 50);
        chk("R4 model agreement", longint'(phase_word), exp_phase());
        err_in = -16'sd17;
        ticks(4);
        chk("R4 negative error floors to -2", longint'(phase_word), 64'h0900_0000 + 42);
    endtask

    task automatic t_lag();
        do_reset();
        arm();
        err_in = 16'sd160; lead_mode = 1'b0;
        ticks(3);
        chk("R5 lagging positive error", longint'(phase_word), 64'h0300_0000 - 30);
        err_in = -16'sd32;
        ticks(2);
        chk("R5 lagging negative error", longint'(phase_word), 64'h0500_0000 - 26);
    endtask

    task automatic t_clamp();
        do_reset();
        off_limit = 31'd25;
        arm();
        err_in = 16'sd160; lead_mode = 1'b1;
        ticks(3);
        chk("R6 positive clamp", longint'(phase_word), 64'h0300_0000 + 25);
        ticks(2);
        chk("R6 positive clamp holds", longint'(phase_word), 64'h0500_0000 + 25);
        err_in = '0; off_limit = 31'd5;
        ticks(1);
        chk("R6 lowered limit pulls offset", longint'(phase_word), 64'h0600_0000 + 5);
        err_in = 16'sd160; lead_mode = 1'b0;
        ticks(2);
        chk("R6 negative clamp", longint'(phase_word), 64'h0800_0000 - 5);
        off_limit = 31'd0; err_in = '0;
        ticks(1);
        chk("R6 zero limit", longint'(phase_word), 64'h0900_0000);
    endtask

    task automatic t_monitor();
        do_reset();
        arm();
        err_in = 16'sd48; lead_mode = 1'b1;
        ticks(4);
        chk("R7 mon before second sync", longint'(offset_mon), 0);
        line_sync = 1'b1;
        tick();
        line_sync = 1'b0;
        chk("R7 mon holds pre-edge offset", longint'(offset_mon), 12);
        chk("R7 phase not reset by sync", longint'(phase_word), 64'h0500_0000 + 15);
        ticks(6);
        chk("R7 mon holds between pulses", longint'(offset_mon), 12);
        chk("R7 model agreement", longint'(phase_word), exp_phase());
        lead_mode = 1'b0;
        line_sync = 1'b1;
        tick();
        line_sync = 1'b0;
        chk("R7 second capture", longint'(offset_mon), m_mon);
        chk("R7 second capture value", longint'(offset_mon), 33);
    endtask

    initial begin
        t_reset_idle();
        t_nominal();
        t_lead();
        t_lag();
        t_clamp();
        t_monitor();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule